// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of a read or write burst in a synchronous DRAM. It models the column ordering that the memory device applies inside a burst, so a controller can keep track of it. A start strobe captures a starting column, a burst length code and an ordering select. From the next cycle the block presents one column per clock, with a beat-valid flag and a final-beat flag. A burst stops early when the stop input is raised, which covers both a burst-stop request and a precharge request. A new start strobe replaces any burst in progress.

Two fixed-length orderings are supported. In sequential order, only the low bits selected by the burst length count upward and wrap. In interleaved order, the beat index is XORed into those low bits. In full-page mode the column counts sequentially across the whole row. It wraps at the end of the row and keeps going until it is stopped.

The control is a three-state machine. The states are `S_IDLE`, `S_BURST` (fixed-length burst) and `S_PAGE` (full-page burst). The transitions are named as follows:
- T_START: `S_IDLE` to `S_BURST` or `S_PAGE` on a start strobe.
- T_RESTART: from `S_BURST` or `S_PAGE` into either burst state on a start strobe.
- T_STOP: from `S_BURST` or `S_PAGE` to `S_IDLE` on the stop input.
- T_DONE: `S_BURST` to `S_IDLE` after the final beat.

Top module: `col_burst_gen`

## Requirements
- R1: After reset `beat_vld_o` and `last_o` are low and `col_o` is zero.
- R2: When `start_i` is sampled high at a clock edge, the first beat appears after that edge. `beat_vld_o` is high and `col_o` equals the sampled `start_col_i`.
- R3: `blen_i` selects the beat count: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. The reserved codes 3'b100 to 3'b110 give 1 beat. A fixed burst shows exactly that many consecutive valid beats, then `beat_vld_o` falls.
- R4: With `ilv_i` low (sequential), beat k of an N-beat burst has column bits above log2(N) equal to the start column. The low log2(N) bits are (start + k) mod N.
- R5: With `ilv_i` high (interleave), beat k has the low log2(N) bits equal to the start column's low bits XOR k. The upper bits equal the start column.
- R6: In full-page mode beat k is at (start + k) mod 512 across the whole row. Beats continue past the row end until stopped, and `ilv_i` has no effect.
- R7: `last_o` is high exactly on the final beat of a fixed-length burst and is never high in full-page mode.
- R8: A burst length of 1 gives a single beat at the start column, with `last_o` high, for either ordering.
- R9: When `stop_i` is sampled high without `start_i`, no further valid beat appears from the next cycle on.
- R10: A `start_i` during a burst abandons it, and the new burst's first beat follows on the next cycle. `start_i` takes priority over `stop_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for a new burst |
| start_col_i | input | 9 | Starting column |
| blen_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| stop_i | input | 1 | Burst-stop or precharge request; ends the burst |
| col_o | output | 9 | Column of the current beat |
| beat_vld_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
The assertions cover the protocol-level behaviour on every cycle:
- A start loads its column on the following beat.
- The final-beat flag only comes with a valid beat and never appears in full-page mode.
- Nothing follows a stop or a final beat.
- Full-page beats step by one modulo the row.

The per-beat column values of sequential and interleaved bursts, the beat counts of each length code, the wrap of a full-page burst past column 511, and the priority of a restart over a stop depend on the full stimulus history. Only the bench's directed scenarios, checked against an independent model of the ordering, can show these.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    // Control states of the burst column generator
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_BURST = 2'd1,
        S_PAGE  = 2'd2
    } state_e;

    // Burst length code values
    localparam logic [2:0] BLC_1    = 3'b000;
    localparam logic [2:0] BLC_2    = 3'b001;
    localparam logic [2:0] BLC_4    = 3'b010;
    localparam logic [2:0] BLC_8    = 3'b011;
    localparam logic [2:0] BLC_PAGE = 3'b111;

endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode #(
    parameter int COL_W = 9
) (
    input  logic [2:0]       code_i,
    output logic [COL_W-1:0] mask_o,
    output logic             page_o
);
    import colgen_pkg::*;

    // Wrap mask: low bits that move within a burst (R3)
    always_comb begin
        page_o = 1'b0;
        mask_o = '0;
        unique case (code_i)
            BLC_1, BLC_2, BLC_4, BLC_8: begin
                mask_o = (COL_W'(1) << code_i[1:0]) - COL_W'(1);
            end
            BLC_PAGE: begin
                page_o = 1'b1;
                mask_o = '1;
            end
            default: begin
                mask_o = '0;   // reserved codes behave as a single beat
            end
        endcase
    end

endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         inc_i,
    output logic [W-1:0] idx_o,
    output logic [W-1:0] idx_nxt_o
);
    logic [W-1:0] idx_q;

    assign idx_nxt_o = idx_q + W'(1);
    assign idx_o     = idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (load_i) begin
            idx_q <= '0;
        end else if (inc_i) begin
            idx_q <= idx_nxt_o;
        end
    end

endmodule

// File: rtl/colgen_order.sv
module colgen_order #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] idx_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum;

    // Carries out of the masked field are dropped by the per-bit select
    assign sum = base_i + idx_i;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_o[b] = !mask_i[b] ? base_i[b]
                        : (ilv_i ? (base_i[b] ^ idx_i[b]) : sum[b]);
    end

endmodule

// File: rtl/col_burst_gen.sv
module col_burst_gen #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       blen_i,
    input  logic             ilv_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_vld_o,
    output logic             last_o
);
    import colgen_pkg::*;

    state_e           state_q, state_d;
    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic [COL_W-1:0] base_q, mask_q;
    logic             ilv_q;
    logic [COL_W-1:0] idx, idx_nxt, ord_col;
    logic [COL_W-1:0] col_q;
    logic             vld_q, last_q;
    logic             page_act;
    logic             advance;

    colgen_len_decode #(.COL_W(COL_W)) u_dec (
        .code_i (blen_i),
        .mask_o (dec_mask),
        .page_o (dec_page)
    );

    assign page_act = (state_q == S_PAGE);
    assign advance  = (state_q != S_IDLE) && !start_i && !stop_i
                      && !(state_q == S_BURST && last_q);

    colgen_beat_ctr #(.W(COL_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (start_i),
        .inc_i     (advance),
        .idx_o     (idx),
        .idx_nxt_o (idx_nxt)
    );

    colgen_order #(.COL_W(COL_W)) u_ord (
        .base_i (base_q),
        .idx_i  (idx_nxt),
        .mask_i (mask_q),
        .ilv_i  (ilv_q),
        .col_o  (ord_col)
    );

    // Next-state logic: T_START, T_RESTART, T_STOP, T_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) state_d = dec_page ? S_PAGE : S_BURST;   // T_START
            end
            S_BURST: begin
                if (start_i)     state_d = dec_page ? S_PAGE : S_BURST; // T_RESTART
                else if (stop_i) state_d = S_IDLE;                      // T_STOP
                else if (last_q) state_d = S_IDLE;                      // T_DONE
            end
            S_PAGE: begin
                if (start_i)     state_d = dec_page ? S_PAGE : S_BURST; // T_RESTART
                else if (stop_i) state_d = S_IDLE;                      // T_STOP
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Output and burst-context registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
            col_q  <= '0;
            vld_q  <= 1'b0;
            last_q <= 1'b0;
        end else if (start_i) begin
            base_q <= start_col_i;
            mask_q <= dec_mask;
            ilv_q  <= ilv_i && !dec_page;
            col_q  <= start_col_i;
            vld_q  <= 1'b1;
            last_q <= (dec_mask == '0) && !dec_page;
        end else if (advance) begin
            col_q  <= ord_col;
            vld_q  <= 1'b1;
            last_q <= !page_act && (idx_nxt == mask_q);
        end else begin
            vld_q  <= 1'b0;
            last_q <= 1'b0;
        end
    end

    assign col_o      = col_q;
    assign beat_vld_o = vld_q;
    assign last_o     = last_q;

    // Beat index is consumed through idx_nxt; keep the current value visible
    logic idx_unused;
    assign idx_unused = ^idx;

endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       blen_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             beat_vld_o,
    input logic             last_o,
    input logic             page_act
);

    AST_START_LOADS_COL: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (beat_vld_o && col_o == $past(start_col_i)));   // R2

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !beat_vld_o);                        // R3

    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (page_act && !start_i && !stop_i) |=> (col_o == $past(col_o) + COL_W'(1))); // R6

    AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        page_act |-> !last_o);                                        // R7

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> beat_vld_o);                                       // R7

    AST_LEN1_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && blen_i == 3'b000) |=> last_o);                    // R8

    AST_STOP_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !beat_vld_o);                        // R9

endmodule

bind col_burst_gen colgen_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .blen_i      (blen_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .beat_vld_o  (beat_vld_o),
    .last_o      (last_o),
    .page_act    (page_act)
);

// File: tb/tb_col_burst_gen.sv
`timescale 1ns/1ps
module tb_col_burst_gen;

    localparam int CW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [CW-1:0] start_col_i = '0;
    logic [2:0]    blen_i = '0;
    logic          ilv_i = 1'b0;
    logic          stop_i = 1'b0;
    logic [CW-1:0] col_o;
    logic          beat_vld_o;
    logic          last_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2 clk = ~clk;   // 250 MHz

    col_burst_gen #(.COL_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .blen_i(blen_i), .ilv_i(ilv_i), .stop_i(stop_i),
        .col_o(col_o), .beat_vld_o(beat_vld_o), .last_o(last_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int beats_of(input logic [2:0] code);
        case (code)
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            default: return 1;
        endcase
    endfunction

    function automatic int model_col(input int base, input int k, input int n,
                                     input bit ilv, input bit page);
        int m;
        if (page) return (base + k) % 512;
        m = n - 1;
        if (ilv) return (base & ~m) | ((base ^ k) & m);
        return (base & ~m) | ((base + k) & m);
    endfunction

    // Start a fixed burst (optionally with stop in the same cycle) and check all beats
    task automatic run_burst(input int col, input logic [2:0] code, input bit ilv,
                             input bit with_stop, input string req);
        int n;
        n = beats_of(code);
        @(negedge clk);
        start_i = 1'b1; start_col_i = CW'(col); blen_i = code; ilv_i = ilv; stop_i = with_stop;
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            chk(beat_vld_o === 1'b1, req, int'(beat_vld_o), 1);
            chk(int'(col_o) == model_col(col, k, n, ilv, 1'b0), req, int'(col_o),
                model_col(col, k, n, ilv, 1'b0));
            chk(last_o === (k == n - 1), {req, "/R7"}, int'(last_o), int'(k == n - 1));
            if (k == 0) begin
                @(negedge clk);
                start_i = 1'b0; stop_i = 1'b0;
            end
        end
        if (n == 1) begin
            @(posedge clk); #1;
        end else begin
            @(posedge clk); #1;
        end
        chk(beat_vld_o === 1'b0, {req, "/R3 end"}, int'(beat_vld_o), 0);
        chk(last_o === 1'b0, {req, "/R3 end"}, int'(last_o), 0);
    endtask

    task automatic t_reset();
        chk(beat_vld_o === 1'b0, "R1 vld", int'(beat_vld_o), 0);
        chk(last_o === 1'b0, "R1 last", int'(last_o), 0);
        chk(col_o === '0, "R1 col", int'(col_o), 0);
    endtask

    task automatic t_sequential();
        run_burst(13, 3'b011, 1'b0, 1'b0, "R4 seq8");
        run_burst(6, 3'b010, 1'b0, 1'b0, "R4 seq4");
        run_burst(511, 3'b001, 1'b0, 1'b0, "R4 seq2");
        run_burst(2, 3'b011, 1'b0, 1'b0, "R2 seq8");
    endtask

    task automatic t_interleave();
        run_burst(13, 3'b011, 1'b1, 1'b0, "R5 ilv8");
        run_burst(7, 3'b010, 1'b1, 1'b0, "R5 ilv4");
        run_burst(301, 3'b001, 1'b1, 1'b0, "R5 ilv2");
    endtask

    task automatic t_len1();
        run_burst(77, 3'b000, 1'b0, 1'b0, "R8 seq");
        run_burst(78, 3'b000, 1'b1, 1'b0, "R8 ilv");
        run_burst(99, 3'b101, 1'b1, 1'b0, "R3 reserved");
    endtask

    task automatic t_page();
        @(negedge clk);
        start_i = 1'b1; start_col_i = CW'(500); blen_i = 3'b111; ilv_i = 1'b1;
        for (int k = 0; k < 530; k++) begin
            @(posedge clk); #1;
            chk(beat_vld_o === 1'b1, "R6 vld", int'(beat_vld_o), 1);
            chk(int'(col_o) == model_col(500, k, 512, 1'b0, 1'b1), "R6 col",
                int'(col_o), model_col(500, k, 512, 1'b0, 1'b1));
            chk(last_o === 1'b0, "R7 page", int'(last_o), 0);
            if (k == 0) begin
                @(negedge clk);
                start_i = 1'b0;
            end
        end
        @(negedge clk);
        stop_i = 1'b1;
        @(posedge clk); #1;
        chk(beat_vld_o === 1'b0, "R9 page stop", int'(beat_vld_o), 1'b0);
        @(negedge clk);
        stop_i = 1'b0;
        @(posedge clk); #1;
        chk(beat_vld_o === 1'b0, "R9 page stays", int'(beat_vld_o), 0);
    endtask

    task automatic t_stop_mid();
        @(negedge clk);
        start_i = 1'b1; start_col_i = CW'(16); blen_i = 3'b011; ilv_i = 1'b0;
        @(posedge clk); #1;
        chk(int'(col_o) == 16, "R2 stop-test first", int'(col_o), 16);
        @(negedge clk);
        start_i = 1'b0;
        @(posedge clk); #1;
        chk(int'(col_o) == 17, "R4 stop-test second", int'(col_o), 17);
        @(negedge clk);
        stop_i = 1'b1;
        @(posedge clk); #1;
        chk(beat_vld_o === 1'b0, "R9 stop", int'(beat_vld_o), 0);
        @(negedge clk);
        stop_i = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); #1;
            chk(beat_vld_o === 1'b0 && last_o === 1'b0, "R9 silent",
                int'(beat_vld_o), 0);
        end
    endtask

    task automatic t_restart();
        @(negedge clk);
        start_i = 1'b1; start_col_i = CW'(40); blen_i = 3'b011; ilv_i = 1'b1;
        @(posedge clk); #1;
        chk(int'(col_o) == 40, "R10 old first", int'(col_o), 40);
        @(negedge clk);
        start_i = 1'b0;
        @(posedge clk); #1;
        chk(int'(col_o) == 41, "R10 old second", int'(col_o), 41);
        // new start with stop in same cycle: start wins
        run_burst(100, 3'b010, 1'b0, 1'b1, "R10 restart");
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_sequential();
        t_interleave();
        t_len1();
        t_page();
        t_stop_mid();
        t_restart();
        repeat (2) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule